// File: doc/BRIEF.md
# Cycle-Steal DMA Transfer Sequencer

This block is a single-channel DMA engine that copies a programmed number of transfer units from a source address to a destination address. Each unit is a read from the source followed by a write to the destination, and both happen inside one bus tenure that the engine wins from the CPU through a request/grant handshake. After each unit the engine gives the bus back. It asks for the bus again only while the active-low request line `dreqN` is held low.

Two operating styles are available. Plain cycle-steal gives the bus up for the shortest possible time between units. Intermittent cycle-steal holds off the next request for a gap of 16 or 64 bus clocks, which lowers the share of bus time that DMA takes. A 16-byte unit is carried as four longword reads into a local buffer, followed by four longword writes, all in the same tenure. Software-style settings are presented on configuration inputs and latched by a one-cycle `start` pulse. `done` reports that the count has run out.

Top module: `dma_steal_seq`

## Requirements
- R1: A `start` pulse while idle or finished latches all `cfg*` inputs and clears `done` in the following cycle. With `cfgCount` = 0 the engine sets `done` without ever raising `busReq`.
- R2: `busReq` rises only in the cycle after a clock edge at which `dreqN` was sampled low and the release gap had expired.
- R3: `memRead` and `memWrite` are asserted only while `busGrant` and `busReq` are both high. `memAddr`, `memWdata` and `memSize` are zero whenever neither strobe is active.
- R4: `cfgUnit` encodes the unit as 0 = byte, 1 = word, 2 = longword, 3 = 16-byte. Every unit is all of its reads from the source followed by all of its writes to the destination, and the two strobes are never high together. `memSize` is 0, 1 or 2 for byte, word or longword cycles.
- R5: A 16-byte unit performs four longword reads at source offsets 0, 4, 8 and 12, then four longword writes at the same destination offsets, within one bus tenure.
- R6: After each unit, both the source and destination addresses advance by the unit size: 1, 2, 4 or 16 bytes.
- R7: Each write carries the data returned by the read at the same beat of the same unit.
- R8: `busReq` falls in the cycle right after the last write of every unit.
- R9: With `cfgIntermittent` = 0 and `dreqN` held low, `busReq` is low for exactly one cycle between units.
- R10: With `cfgIntermittent` = 1 and `dreqN` held low, `busReq` is low for exactly 17 cycles between units when `cfgGapLong` = 0, and for 65 cycles when `cfgGapLong` = 1. That is one release cycle plus the gap.
- R11: After `cfgCount` units, `done` goes high, `busReq` stays low, and `done` holds until the next `start`.
- R12: While `dreqN` is high, no new bus request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that latches the configuration and starts a transfer |
| cfgSrc | input | AW | Starting source address |
| cfgDst | input | AW | Starting destination address |
| cfgCount | input | CW | Number of units to transfer |
| cfgUnit | input | 2 | Unit size code (0 byte, 1 word, 2 longword, 3 16-byte) |
| cfgIntermittent | input | 1 | 1 selects intermittent cycle-steal |
| cfgGapLong | input | 1 | Intermittent gap: 0 gives 16 clocks, 1 gives 64 clocks |
| dreqN | input | 1 | Active-low level-sensitive transfer request |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| memAddr | output | AW | Bus address |
| memRead | output | 1 | Read strobe |
| memWrite | output | 1 | Write strobe |
| memSize | output | 2 | Access size (0 byte, 1 word, 2 longword) |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, sampled at the clock edge that ends a read cycle |
| done | output | 1 | Transfer complete |

## Verification
Two events can land in the same cycle: the end of the release gap, and the sampling of a still-low `dreqN` that starts the next request. The bench provokes this by holding `dreqN` low through whole runs in every mode and unit size. It then measures the exact low time of `busReq` between units, which must equal the release cycle plus the programmed gap with no extra cycle lost. A second run keeps `dreqN` high after start and only lowers it later, to confirm that an expired gap alone never raises a request.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_REQ,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } seqState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic load;      // latch configuration
    logic capture;   // store read data of the current beat
    logic beatInc;   // advance to the next beat
    logic beatClr;   // return beat to zero
    logic unitDone;  // advance addresses, decrement count, load gap
    logic gapDec;    // count the release gap down
    logic selWrite;  // address from destination instead of source
  } dpStrobe_t;

  // conditions reported back to control
  typedef struct packed {
    logic countZero;
    logic gapZero;
    logic lastBeat;
  } dpStatus_t;

  localparam logic [1:0] UNIT_BYTE = 2'd0;
  localparam logic [1:0] UNIT_WORD = 2'd1;
  localparam logic [1:0] UNIT_LONG = 2'd2;
  localparam logic [1:0] UNIT_QUAD = 2'd3;

endpackage

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
  import dma_steal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dreqN,
  input  logic       busGrant,
  input  dpStatus_t  stat,
  output dpStrobe_t  strb,
  output logic       busReq,
  output logic       readAct,
  output logic       writeAct,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = ST_ARB;
        end
      end
      ST_ARB: begin
        if (stat.countZero) begin
          nextState = ST_FIN;
        end else begin
          if (!stat.gapZero) strb.gapDec = 1'b1;
          else if (!dreqN)   nextState = ST_REQ;
        end
      end
      ST_REQ: begin
        if (busGrant) nextState = ST_READ;
      end
      ST_READ: begin
        if (busGrant) begin
          strb.capture = 1'b1;
          if (stat.lastBeat) begin
            strb.beatClr = 1'b1;
            nextState    = ST_WRITE;
          end else begin
            strb.beatInc = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        strb.selWrite = 1'b1;
        if (busGrant) begin
          if (stat.lastBeat) begin
            strb.beatClr  = 1'b1;
            strb.unitDone = 1'b1;
            nextState     = ST_ARB;
          end else begin
            strb.beatInc = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busReq   = (state == ST_REQ) || (state == ST_READ) || (state == ST_WRITE);
  assign readAct  = (state == ST_READ)  && busGrant;
  assign writeAct = (state == ST_WRITE) && busGrant;
  assign done     = (state == ST_FIN);

endmodule

// File: rtl/dma_steal_dp.sv
module dma_steal_dp
  import dma_steal_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 8,
  parameter int DW        = 32,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [AW-1:0] cfgSrc,
  input  logic [AW-1:0] cfgDst,
  input  logic [CW-1:0] cfgCount,
  input  logic [1:0]    cfgUnit,
  input  logic          cfgIntermittent,
  input  logic          cfgGapLong,
  input  logic [DW-1:0] rdata,
  output dpStatus_t     stat,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [1:0]    size
);

  localparam int BEATS = 4;
  localparam int BW    = $clog2(BEATS);
  localparam int GW    = $clog2(GAP_LONG + 1);
  localparam int LANE  = DW / 8;

  logic [AW-1:0] srcAddr, dstAddr, unitBytes, beatOff;
  logic [CW-1:0] count;
  logic [1:0]    unitSel;
  logic          interMode, gapLongSel, multiBeat;
  logic [GW-1:0] gapCnt, gapLoad;
  logic [BW-1:0] beat;
  logic [DW-1:0] bufWord [BEATS];

  always_comb begin
    case (unitSel)
      UNIT_BYTE: unitBytes = AW'(1);
      UNIT_WORD: unitBytes = AW'(2);
      UNIT_LONG: unitBytes = AW'(LANE);
      default:   unitBytes = AW'(LANE * BEATS);
    endcase
  end

  assign multiBeat = (unitSel == UNIT_QUAD);
  assign beatOff   = AW'(beat) * AW'(LANE);
  assign gapLoad   = !interMode  ? '0 :
                     gapLongSel  ? GW'(GAP_LONG) : GW'(GAP_SHORT);

  // configuration and progress registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr    <= '0;
      dstAddr    <= '0;
      count      <= '0;
      unitSel    <= UNIT_BYTE;
      interMode  <= 1'b0;
      gapLongSel <= 1'b0;
    end else if (strb.load) begin
      srcAddr    <= cfgSrc;
      dstAddr    <= cfgDst;
      count      <= cfgCount;
      unitSel    <= cfgUnit;
      interMode  <= cfgIntermittent;
      gapLongSel <= cfgGapLong;
    end else if (strb.unitDone) begin
      srcAddr <= srcAddr + unitBytes;
      dstAddr <= dstAddr + unitBytes;
      count   <= count - 1'b1;
    end
  end

  // release gap counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= '0;
    else if (strb.load)     gapCnt <= '0;
    else if (strb.unitDone) gapCnt <= gapLoad;
    else if (strb.gapDec)   gapCnt <= gapCnt - 1'b1;
  end

  // beat counter within a unit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             beat <= '0;
    else if (strb.load)    beat <= '0;
    else if (strb.beatClr) beat <= '0;
    else if (strb.beatInc) beat <= beat + 1'b1;
  end

  // staging buffer, one word per beat
  for (genvar gi = 0; gi < BEATS; gi++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   bufWord[gi] <= '0;
      else if (strb.capture && beat == BW'(gi))    bufWord[gi] <= rdata;
    end
  end

  assign stat.countZero = (count == '0);
  assign stat.gapZero   = (gapCnt == '0);
  assign stat.lastBeat  = !multiBeat || (beat == BW'(BEATS - 1));

  assign addr  = (strb.selWrite ? dstAddr : srcAddr) + beatOff;
  assign wdata = bufWord[beat];
  assign size  = multiBeat ? UNIT_LONG : unitSel;

endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_steal_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 8,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] cfgSrc,
  input  logic [AW-1:0] cfgDst,
  input  logic [CW-1:0] cfgCount,
  input  logic [1:0]    cfgUnit,
  input  logic          cfgIntermittent,
  input  logic          cfgGapLong,
  input  logic          dreqN,
  output logic          busReq,
  input  logic          busGrant,
  output logic [AW-1:0] memAddr,
  output logic          memRead,
  output logic          memWrite,
  output logic [1:0]    memSize,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          done
);

  dpStrobe_t     strb;
  dpStatus_t     stat;
  logic          readAct, writeAct, busActive;
  logic [AW-1:0] dpAddr;
  logic [31:0]   dpWdata;
  logic [1:0]    dpSize;

  dma_steal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .dreqN    (dreqN),
    .busGrant (busGrant),
    .stat     (stat),
    .strb     (strb),
    .busReq   (busReq),
    .readAct  (readAct),
    .writeAct (writeAct),
    .done     (done)
  );

  dma_steal_dp #(
    .AW(AW), .CW(CW), .DW(32), .GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .cfgSrc          (cfgSrc),
    .cfgDst          (cfgDst),
    .cfgCount        (cfgCount),
    .cfgUnit         (cfgUnit),
    .cfgIntermittent (cfgIntermittent),
    .cfgGapLong      (cfgGapLong),
    .rdata           (memRdata),
    .stat            (stat),
    .addr            (dpAddr),
    .wdata           (dpWdata),
    .size            (dpSize)
  );

  // bus outputs stay quiet unless a granted access is in progress
  assign busActive = readAct || writeAct;
  assign memRead   = readAct;
  assign memWrite  = writeAct;
  assign memAddr   = busActive ? dpAddr  : '0;
  assign memSize   = busActive ? dpSize  : '0;
  assign memWdata  = writeAct  ? dpWdata : '0;

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic cfgIntermittent,
  input logic cfgGapLong,
  input logic dreqN,
  input logic busReq,
  input logic busGrant,
  input logic memRead,
  input logic memWrite,
  input logic done
);

  logic [7:0] lowCnt;
  logic [7:0] needLow;
  logic       hadTenure, prevReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt    <= '0;
      needLow   <= 8'd1;
      hadTenure <= 1'b0;
      prevReq   <= 1'b0;
    end else begin
      prevReq <= busReq;
      if (busReq)              lowCnt <= '0;
      else if (lowCnt != 8'hFF) lowCnt <= lowCnt + 1'b1;
      if (start) begin
        hadTenure <= 1'b0;
        needLow   <= !cfgIntermittent ? 8'd1 :
                     cfgGapLong ? 8'(GAP_LONG + 1) : 8'(GAP_SHORT + 1);
      end else if (busReq) begin
        hadTenure <= 1'b1;
      end
    end
  end

  // R3
  bus_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |-> (busGrant && busReq));

  // R4
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  // R2
  req_on_dreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !$past(dreqN));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq);

  // R10
  gap_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !prevReq && hadTenure) |-> (lowCnt >= needLow));

endmodule

bind dma_steal_seq dma_steal_chk #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .start           (start),
  .cfgIntermittent (cfgIntermittent),
  .cfgGapLong      (cfgGapLong),
  .dreqN           (dreqN),
  .busReq          (busReq),
  .busGrant        (busGrant),
  .memRead         (memRead),
  .memWrite        (memWrite),
  .done            (done)
);

// File: tb/dma_steal_seq_bench.sv
module dma_steal_seq_bench;

  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfgSrc = '0, cfgDst = '0;
  logic [CW-1:0] cfgCount = '0;
  logic [1:0]    cfgUnit = '0;
  logic          cfgIntermittent = 1'b0, cfgGapLong = 1'b0;
  logic          dreqN = 1'b0;
  logic          busReq, busGrant = 1'b0;
  logic [AW-1:0] memAddr;
  logic          memRead, memWrite, done;
  logic [1:0]    memSize;
  logic [31:0]   memWdata, memRdata;

  always #4 clk = ~clk;

  // memory content is a pure function of the address
  assign memRdata = {memAddr, ~memAddr};

  // arbiter: grant follows request by one cycle
  always @(posedge clk) busGrant <= rstN ? busReq : 1'b0;

  dma_steal_seq #(.AW(AW), .CW(CW)) u_dma_steal_seq (
    .clk(clk), .rstN(rstN), .start(start), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgCount(cfgCount), .cfgUnit(cfgUnit), .cfgIntermittent(cfgIntermittent),
    .cfgGapLong(cfgGapLong), .dreqN(dreqN), .busReq(busReq), .busGrant(busGrant),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .done(done)
  );

  int vectors = 0, fails = 0;
  int curBytes, curBeats, curCnt, expGap, rdIdx, wrIdx, lowRun;
  logic [1:0]    curUnit;
  logic [AW-1:0] curSrc, curDst;
  bit runActive = 0, hadTen = 0, prevReq = 0, expectDrop = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] base, input int idx);
    return base + AW'((idx / curBeats) * curBytes + (idx % curBeats) * 4);
  endfunction

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (runActive && rstN) begin
      if (expectDrop) begin
        chk(busReq == 1'b0, "R8 busReq after last write", 64'(busReq), 64'd0);
        expectDrop = 0;
      end
      if ((memRead || memWrite) && !busGrant)
        chk(1'b0, "R3 strobe without grant", 64'(busGrant), 64'd1);
      if (memRead) begin
        chk(memAddr == beatAddr(curSrc, rdIdx), "R5 R6 read address", 64'(memAddr), 64'(beatAddr(curSrc, rdIdx)));
        chk(memSize == ((curUnit == 2'd3) ? 2'd2 : curUnit), "R4 read size", 64'(memSize), 64'(curUnit));
        chk(rdIdx / curBeats == wrIdx / curBeats && wrIdx % curBeats == 0, "R4 read before write", 64'(rdIdx), 64'(wrIdx));
        rdIdx++;
      end
      if (memWrite) begin
        chk(memAddr == beatAddr(curDst, wrIdx), "R5 R6 write address", 64'(memAddr), 64'(beatAddr(curDst, wrIdx)));
        chk(memWdata == {beatAddr(curSrc, wrIdx), ~beatAddr(curSrc, wrIdx)}, "R7 write data",
            64'(memWdata), 64'({beatAddr(curSrc, wrIdx), ~beatAddr(curSrc, wrIdx)}));
        wrIdx++;
        if (wrIdx % curBeats == 0) expectDrop = 1;
      end
      if (busReq) begin
        if (!prevReq && hadTen)
          chk(lowRun == expGap + 1, "R9 R10 release gap", 64'(lowRun), 64'(expGap + 1));
        hadTen = 1;
        lowRun = 0;
      end else begin
        lowRun++;
      end
      prevReq = busReq;
    end
  end

  task automatic launch(input logic [1:0] unit, input bit inter, input bit glong, input int cnt,
                        input logic [AW-1:0] src, input logic [AW-1:0] dst);
    @(negedge clk);
    curUnit = unit; curCnt = cnt; curSrc = src; curDst = dst;
    curBytes = (unit == 2'd0) ? 1 : (unit == 2'd1) ? 2 : (unit == 2'd2) ? 4 : 16;
    curBeats = (unit == 2'd3) ? 4 : 1;
    expGap   = !inter ? 0 : glong ? 64 : 16;
    rdIdx = 0; wrIdx = 0; lowRun = 0; hadTen = 0; prevReq = 0; expectDrop = 0;
    cfgUnit = unit; cfgIntermittent = inter; cfgGapLong = glong;
    cfgCount = CW'(cnt); cfgSrc = src; cfgDst = dst;
    start = 1'b1;
    runActive = 1;
    @(negedge clk);
    start = 1'b0;
    if (cnt > 0) chk(done == 1'b0, "R1 done cleared by start", 64'(done), 64'd0);
  endtask

  task automatic finishRun(input string tag);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R11 done reached", 64'(done), 64'd1);
    chk(rdIdx == curCnt * curBeats, "R11 read count", 64'(rdIdx), 64'(curCnt * curBeats));
    chk(wrIdx == curCnt * curBeats, "R11 write count", 64'(wrIdx), 64'(curCnt * curBeats));
    repeat (4) @(negedge clk);
    chk(done == 1'b1 && busReq == 1'b0, "R11 done held, bus idle", 64'({done, busReq}), 64'b10);
    runActive = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busReq == 1'b0 && done == 1'b0 && memRead == 1'b0 && memWrite == 1'b0,
        "R3 reset state", 64'({busReq, done, memRead, memWrite}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: zero count finishes with no bus request
    launch(2'd2, 1'b0, 1'b0, 0, 16'h0100, 16'h0200);
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R1 zero count done", 64'(done), 64'd1);
    chk(hadTen == 0, "R1 zero count no request", 64'(hadTen), 64'd0);
    runActive = 0;

    // sweep every unit size in every mode with DREQ held low (R4 R5 R6 R7 R8 R9 R10)
    for (int u = 0; u < 4; u++) begin
      for (int m = 0; m < 3; m++) begin
        launch(2'(u), m != 0, m == 2, 3, 16'h1000 + 16'(u * 16'h0101), 16'h8000 + 16'(m * 16'h0040));
        finishRun("sweep");
      end
    end

    // R12: no request while DREQ is high
    dreqN = 1'b1;
    launch(2'd1, 1'b1, 1'b0, 2, 16'h2000, 16'h3000);
    repeat (40) @(negedge clk);
    chk(hadTen == 0 && busReq == 1'b0, "R12 no request with DREQ high", 64'(hadTen), 64'd0);
    dreqN = 1'b0;
    finishRun("late dreq");

    // R2: a single request after DREQ falls, at the next clock
    dreqN = 1'b1;
    launch(2'd0, 1'b0, 1'b0, 1, 16'h0400, 16'h0500);
    repeat (5) @(negedge clk);
    dreqN = 1'b0;
    @(negedge clk);
    chk(busReq == 1'b1, "R2 request one clock after DREQ low", 64'(busReq), 64'd1);
    finishRun("dreq edge");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule